// File: doc/BRIEF.md
# Transmit Byte Queue with Watermark Events

This block is the transmit byte queue of a serial peripheral. Software pushes bytes into it through the write-data path, and the serializer drains them through a byte-plus-valid handshake. The queue keeps its own fill count. From that count it derives the full and empty status bits and a 5-bit level field for the FIFO status register. It also compares the count against a watermark that software selects, and produces single-cycle event pulses for the interrupt bank.

Software controls the queue through a FIFO control register. Bits 6:5 of that register select the watermark. Writing a one to bit 1 empties the queue in a single cycle, and that bit reads back as zero. Bit 0 is the receive-side reset. It belongs to the receive queue and has no effect here. Bytes leave the queue only while transmit is enabled. A push into a full queue is discarded.

Top module: `txq_wmark`

## Requirements
- R1: After reset, lvl_o is 0, empty_o is 1, full_o, wm_o, evt_wmark_o, evt_empty_o and pop_valid_o are 0, and ctrl_o is 0.
- R2: A push that is accepted stores push_data_i at the tail and raises the level by one. pop_valid_o equals tx_en_i AND (level not 0). While pop_valid_o is high, pop_data_o shows the oldest byte. A pop happens on a clock edge where pop_valid_o and pop_ready_i are both high. Bytes leave in the order they were pushed.
- R3: A push while the level is 32 is dropped, even in a cycle that also pops. Its byte is never delivered.
- R4: full_o is 1 exactly when the level is 32. empty_o is 1 exactly when the level is 0. Both reflect the level after the most recent edge.
- R5: lvl_o carries the level modulo 32 (bits 4:0 of the status field), so a full queue reads 0 with full_o set.
- R6: The watermark code in control bits 6:5 maps 0, 1, 2 and 3 to levels 1, 4, 8 and 16. A newly written code is first used at the edge after the write.
- R7: evt_wmark_o pulses for one cycle after every accepted push that leaves the level at or above the watermark.
- R8: wm_o is set together with evt_wmark_o. It is cleared after any edge that leaves the level below the watermark. This includes a full drain and a raised watermark. Otherwise it holds.
- R9: evt_empty_o pulses for one cycle after a pop that takes the level from 1 to 0 with no push in the same cycle.
- R10: While tx_en_i is 0, pop_ready_i is ignored and no byte leaves the queue.
- R11: A control write with bit 1 set does all of the following in one cycle: it clears the level and both pointers, clears wm_o, and overrides any push or pop in that cycle. It raises no event pulse. ctrl_o keeps only bits 6:5 of the write, so bits 1 and 0 read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Write-data push strobe |
| push_data_i | input | 8 | Byte to enqueue |
| cfg_wr_i | input | 1 | FIFO control register write strobe |
| cfg_wdata_i | input | 8 | FIFO control write value (bit 1 queue reset, bits 6:5 watermark code) |
| tx_en_i | input | 1 | Transmit enable from the control register |
| pop_ready_i | input | 1 | Serializer takes the offered byte |
| pop_valid_o | output | 1 | A byte is offered to the serializer |
| pop_data_o | output | 8 | Oldest queued byte |
| lvl_o | output | 5 | Level field, level modulo 32 |
| full_o | output | 1 | Full status bit |
| empty_o | output | 1 | Empty status bit |
| wm_o | output | 1 | Watermark condition |
| evt_wmark_o | output | 1 | Watermark event pulse |
| evt_empty_o | output | 1 | Empty event pulse |
| ctrl_o | output | 8 | FIFO control register readback |

## Verification
A miscounted level shows on lvl_o, full_o or empty_o on the edge right after the faulty update. A wrong watermark state appears on wm_o or evt_wmark_o only at the next push or the next crossing of the watermark. A corrupted pointer or storage entry stays hidden until the affected byte reaches the head, which can be up to 32 pops later. For that reason the sweeps fill the queue completely and drain it completely for every watermark code, and they compare every byte that leaves.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned CFG_W         = 8;
    localparam int unsigned CFG_RXRST_BIT = 0;
    localparam int unsigned CFG_TXRST_BIT = 1;
    localparam int unsigned CFG_THR_LSB   = 5;
    localparam int unsigned CFG_THR_W     = 2;

    typedef enum logic [1:0] {
        WM_ONE     = 2'd0,
        WM_FOUR    = 2'd1,
        WM_EIGHT   = 2'd2,
        WM_SIXTEEN = 2'd3
    } wm_sel_e;

    function automatic int unsigned wm_level(input wm_sel_e sel);
        int unsigned lvl;
        case (sel)
            WM_ONE:   lvl = 1;
            WM_FOUR:  lvl = 4;
            WM_EIGHT: lvl = 8;
            default:  lvl = 16;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/txq_cfg.sv
module txq_cfg
    import txq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             clr_o,
    output wm_sel_e          sel_o,
    output logic [CFG_W-1:0] ctrl_o
);

    wm_sel_e sel_d, sel_q;
    logic    unused_cfg_bits;

    always_comb begin
        sel_d = sel_q;
        if (cfg_wr_i) begin
            sel_d = wm_sel_e'(cfg_wdata_i[CFG_THR_LSB +: CFG_THR_W]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= WM_ONE;
        end else begin
            sel_q <= sel_d;
        end
    end

    // queue reset is a strobe only; it is never stored, so it reads back 0
    assign clr_o = cfg_wr_i && cfg_wdata_i[CFG_TXRST_BIT];
    assign sel_o = sel_q;

    always_comb begin
        ctrl_o = '0;
        ctrl_o[CFG_THR_LSB +: CFG_THR_W] = sel_q;
    end

    // receive reset and spare bits belong to other blocks
    assign unused_cfg_bits = ^{cfg_wdata_i[CFG_RXRST_BIT], cfg_wdata_i[4:2], cfg_wdata_i[7]};

endmodule

// File: rtl/txq_thresh.sv
module txq_thresh
    import txq_pkg::*;
#(
    parameter int unsigned LW = 6
) (
    input  wm_sel_e       sel_i,
    output logic [LW-1:0] thr_o
);

    always_comb begin
        thr_o = LW'(wm_level(sel_i));
    end

endmodule

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] rd_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] ent_q;
        always_ff @(posedge clk_i) begin
            if (we_i && (waddr_i == AW'(i))) begin
                ent_q <= wdata_i;
            end
        end
        assign rd_arr[i] = ent_q;
    end

    assign rdata_o = rd_arr[raddr_i];

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic          pop_ready_i,
    input  logic          tx_en_i,
    input  logic          clr_i,
    input  logic [LW-1:0] thr_i,
    output logic          we_o,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o,
    output logic [LW-1:0] lvl_o,
    output logic          pop_valid_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          wm_o,
    output logic          ev_wm_o,
    output logic          ev_emp_o
);

    typedef struct packed {
        logic [LW-1:0] lvl;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic          full;
        logic          empty;
        logic          wm;
        logic          ev_wm;
        logic          ev_emp;
    } state_t;

    localparam state_t RST_STATE = '{
        lvl: '0, wptr: '0, rptr: '0, full: 1'b0, empty: 1'b1,
        wm: 1'b0, ev_wm: 1'b0, ev_emp: 1'b0
    };

    state_t        st_d, st_q;
    logic          push_ok, pop_ok;
    logic [LW-1:0] lvl_n;

    assign pop_valid_o = tx_en_i && (st_q.lvl != '0);
    assign pop_ok      = pop_valid_o && pop_ready_i && !clr_i;
    // a full queue drops the push even when a pop frees a slot this cycle
    assign push_ok     = push_i && (st_q.lvl != LW'(DEPTH)) && !clr_i;
    assign lvl_n       = st_q.lvl + LW'(push_ok) - LW'(pop_ok);

    always_comb begin
        st_d        = st_q;
        st_d.ev_wm  = 1'b0;
        st_d.ev_emp = 1'b0;
        if (clr_i) begin
            st_d = RST_STATE;
        end else begin
            st_d.lvl   = lvl_n;
            st_d.wptr  = st_q.wptr + AW'(push_ok);
            st_d.rptr  = st_q.rptr + AW'(pop_ok);
            st_d.full  = (lvl_n == LW'(DEPTH));
            st_d.empty = (lvl_n == '0);
            if (push_ok && (lvl_n >= thr_i)) begin
                st_d.wm    = 1'b1;
                st_d.ev_wm = 1'b1;
            end else if (lvl_n < thr_i) begin
                st_d.wm = 1'b0;
            end
            st_d.ev_emp = pop_ok && !push_ok && (st_q.lvl == LW'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o     = push_ok;
    assign wptr_o   = st_q.wptr;
    assign rptr_o   = st_q.rptr;
    assign lvl_o    = st_q.lvl;
    assign full_o   = st_q.full;
    assign empty_o  = st_q.empty;
    assign wm_o     = st_q.wm;
    assign ev_wm_o  = st_q.ev_wm;
    assign ev_emp_o = st_q.ev_emp;

endmodule

// File: rtl/txq_wmark.sv
module txq_wmark
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DW     = 8,
    parameter int unsigned STAT_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_valid_i,
    input  logic [DW-1:0]     push_data_i,
    input  logic              cfg_wr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              tx_en_i,
    input  logic              pop_ready_i,
    output logic              pop_valid_o,
    output logic [DW-1:0]     pop_data_o,
    output logic [STAT_W-1:0] lvl_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              wm_o,
    output logic              evt_wmark_o,
    output logic              evt_empty_o,
    output logic [CFG_W-1:0]  ctrl_o
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic          clr;
    wm_sel_e       sel;
    logic [LW-1:0] thr;
    logic          we;
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] lvl;
    logic          unused_lvl_hi;

    txq_cfg u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .clr_o       (clr),
        .sel_o       (sel),
        .ctrl_o      (ctrl_o)
    );

    txq_thresh #(.LW(LW)) u_thr (
        .sel_i (sel),
        .thr_o (thr)
    );

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_valid_i),
        .pop_ready_i (pop_ready_i),
        .tx_en_i     (tx_en_i),
        .clr_i       (clr),
        .thr_i       (thr),
        .we_o        (we),
        .wptr_o      (wptr),
        .rptr_o      (rptr),
        .lvl_o       (lvl),
        .pop_valid_o (pop_valid_o),
        .full_o      (full_o),
        .empty_o     (empty_o),
        .wm_o        (wm_o),
        .ev_wm_o     (evt_wmark_o),
        .ev_emp_o    (evt_empty_o)
    );

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk_i   (clk_i),
        .we_i    (we),
        .waddr_i (wptr),
        .wdata_i (push_data_i),
        .raddr_i (rptr),
        .rdata_o (pop_data_o)
    );

    // the status field is narrower than the count; full_o tells 32 from 0
    assign lvl_o         = lvl[STAT_W-1:0];
    assign unused_lvl_hi = ^lvl;

endmodule

// File: rtl/txq_wmark_chk.sv
module txq_wmark_chk #(
    parameter int unsigned STAT_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              push_valid_i,
    input logic              cfg_wr_i,
    input logic [7:0]        cfg_wdata_i,
    input logic              tx_en_i,
    input logic              pop_ready_i,
    input logic              pop_valid_o,
    input logic [STAT_W-1:0] lvl_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              wm_o,
    input logic              evt_wmark_o,
    input logic              evt_empty_o
);

    p_full_empty_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full_o && empty_o));

    p_pop_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_valid_o |-> (tx_en_i && !empty_o));

    p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !(pop_valid_o && pop_ready_i) && !(cfg_wr_i && cfg_wdata_i[1]))
        |=> full_o);

    p_level_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_valid_i && !full_o && !(pop_valid_o && pop_ready_i)
         && !(cfg_wr_i && cfg_wdata_i[1]))
        |=> (lvl_o == STAT_W'($past(lvl_o) + 1'b1)));

    p_wm_evt_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_wmark_o |-> wm_o);

    p_empty_evt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_empty_o |-> empty_o);

    p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && cfg_wdata_i[1])
        |=> (empty_o && !wm_o && !evt_empty_o && !evt_wmark_o));

endmodule

bind txq_wmark txq_wmark_chk #(.STAT_W(STAT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (push_valid_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .tx_en_i      (tx_en_i),
    .pop_ready_i  (pop_ready_i),
    .pop_valid_o  (pop_valid_o),
    .lvl_o        (lvl_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .wm_o         (wm_o),
    .evt_wmark_o  (evt_wmark_o),
    .evt_empty_o  (evt_empty_o)
);

// File: tb/sim_txq_wmark.sv
`timescale 1ns/1ps
module sim_txq_wmark;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       push_valid_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic       tx_en_i = 1'b0;
    logic       pop_ready_i = 1'b0;
    logic       pop_valid_o;
    logic [7:0] pop_data_o;
    logic [4:0] lvl_o;
    logic       full_o, empty_o, wm_o, evt_wmark_o, evt_empty_o;
    logic [7:0] ctrl_o;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [7:0] mq [32];
    int mhead = 0, mtail = 0, mlvl = 0, mcode = 0;
    bit mwm = 0, mew = 0, mee = 0;

    always #2.5 clk_i = ~clk_i;

    txq_wmark u0 (
        .clk_i, .rst_ni, .push_valid_i, .push_data_i, .cfg_wr_i, .cfg_wdata_i,
        .tx_en_i, .pop_ready_i, .pop_valid_o, .pop_data_o, .lvl_o, .full_o,
        .empty_o, .wm_o, .evt_wmark_o, .evt_empty_o, .ctrl_o
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int thr_of(input int code);
        return (code == 0) ? 1 : (1 << (code + 1));
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit push, input logic [7:0] d, input bit rdy,
                        input bit en, input bit cw, input logic [7:0] cwd);
        bit clr, push_ok, pop_ok;
        int nl;
        push_valid_i = push; push_data_i = d; pop_ready_i = rdy;
        tx_en_i = en; cfg_wr_i = cw; cfg_wdata_i = cwd;
        #1;
        chk("R2 pop_valid (R10 enable)", int'(pop_valid_o), int'(en && mlvl > 0));
        if (en && mlvl > 0) chk("R2 head byte", int'(pop_data_o), int'(mq[mhead]));
        @(posedge clk_i);
        clr = cw && cwd[1];
        if (clr) begin
            mlvl = 0; mhead = 0; mtail = 0; mwm = 0; mew = 0; mee = 0;
        end else begin
            push_ok = push && (mlvl < 32);
            pop_ok  = en && (mlvl > 0) && rdy;
            if (pop_ok) mhead = (mhead + 1) % 32;
            if (push_ok) begin mq[mtail] = d; mtail = (mtail + 1) % 32; end
            nl  = mlvl + int'(push_ok) - int'(pop_ok);
            mew = push_ok && (nl >= thr_of(mcode));
            if (mew) mwm = 1;
            else if (nl < thr_of(mcode)) mwm = 0;
            mee = pop_ok && (nl == 0);
            mlvl = nl;
        end
        if (cw) mcode = int'(cwd[6:5]);
        @(negedge clk_i);
        chk("R5 level field", int'(lvl_o), mlvl % 32);
        chk("R4 full", int'(full_o), int'(mlvl == 32));
        chk("R4 empty", int'(empty_o), int'(mlvl == 0));
        chk("R7 wmark pulse (R6 threshold)", int'(evt_wmark_o), int'(mew));
        chk("R8 wmark state", int'(wm_o), int'(mwm));
        chk("R9 empty pulse", int'(evt_empty_o), int'(mee));
        chk("R11 ctrl readback", int'(ctrl_o), mcode << 5);
    endtask

    task automatic drain();
        int k = 0;
        while (mlvl > 0) begin
            step(0, 8'h00, (k % 3) != 1, 1, 0, 8'h00);
            k++;
        end
        step(0, 8'h00, 1, 1, 0, 8'h00);
    endtask

    initial begin
        repeat (1000) @(posedge clk_i);
        repeat (99000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        // R1 reset state
        chk("R1 level", int'(lvl_o), 0);
        chk("R1 empty", int'(empty_o), 1);
        chk("R1 full", int'(full_o), 0);
        chk("R1 wm", int'(wm_o), 0);
        chk("R1 events", int'(evt_wmark_o) + int'(evt_empty_o), 0);
        chk("R1 pop_valid", int'(pop_valid_o), 0);
        chk("R1 ctrl", int'(ctrl_o), 0);
        @(negedge clk_i);

        // full sweep per watermark code: fill past full, hit, drain
        for (int c = 0; c < 4; c++) begin
            step(0, 8'h00, 0, 0, 1, 8'(c << 5));
            for (int i = 0; i < 33; i++) begin
                step(1, 8'(c * 40 + i), 1, 0, 0, 8'h00);
            end
            chk("R3 full after overfill", int'(full_o), 1);
            chk("R3 level field at full", int'(lvl_o), 0);
            #1;
            chk("R10 nothing left while disabled", int'(pop_data_o), int'(8'(c * 40)));
            step(1, 8'hEE, 1, 1, 0, 8'h00);
            chk("R3 push dropped during pop at full", int'(lvl_o), 31);
            drain();
        end

        // mixed push and pop traffic around watermark 4
        step(0, 8'h00, 0, 0, 1, 8'h20);
        for (int k = 0; k < 60; k++) begin
            step((k % 4) != 3, 8'(k + 100), (k % 2) == 0, 1, 0, 8'h00);
        end
        drain();

        // push and pop together at level 1: no empty pulse
        step(1, 8'h11, 0, 1, 0, 8'h00);
        step(1, 8'h22, 1, 1, 0, 8'h00);
        chk("R9 no pulse when push offsets pop", int'(evt_empty_o), 0);
        drain();

        // queue reset overrides a push, clears everything, self-clears
        step(0, 8'h00, 0, 0, 1, 8'h40);
        for (int i = 0; i < 10; i++) step(1, 8'(i + 1), 0, 0, 0, 8'h00);
        chk("R8 wm set at 10 of 8", int'(wm_o), 1);
        step(1, 8'h55, 1, 1, 1, 8'h63);
        chk("R11 level cleared", int'(lvl_o), 0);
        chk("R11 empty set", int'(empty_o), 1);
        chk("R11 no empty pulse", int'(evt_empty_o), 0);
        chk("R11 wm cleared", int'(wm_o), 0);
        chk("R11 reset bits read 0", int'(ctrl_o), 8'h60);
        step(1, 8'hA7, 0, 0, 0, 8'h00);
        #1;
        chk("R11 pointers restart", int'(pop_data_o), 8'hA7);
        drain();

        // raising the watermark clears the condition one edge later
        step(0, 8'h00, 0, 0, 1, 8'h00);
        step(1, 8'h31, 0, 0, 0, 8'h00);
        step(1, 8'h32, 0, 0, 0, 8'h00);
        chk("R8 wm set at threshold 1", int'(wm_o), 1);
        step(0, 8'h00, 0, 0, 1, 8'h60);
        chk("R6 old threshold still applies", int'(wm_o), 1);
        step(0, 8'h00, 0, 0, 0, 8'h00);
        chk("R8 wm cleared below 16", int'(wm_o), 0);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule